// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge and Completion Interface

This block sits between an interrupt distributor and one processor. Each cycle the distributor offers its best pending candidate (an interrupt ID, an 8-bit priority and, for software-generated interrupts, the number of the CPU that raised it). The block decides whether that candidate may interrupt the processor. It checks the candidate against a software-set priority threshold and against the priority of the interrupt the processor is already handling. If the candidate passes, the block drives the interrupt request line.

The processor reaches the block through a small register port with four registers: control, priority threshold, acknowledge and completion. Reading the acknowledge register claims the offered interrupt. The read returns the ID and the source field, pushes the interrupt's priority onto a running-priority stack, and sends a one-cycle claim pulse back to the distributor so that it can mark the interrupt active and clear its pending state. If nothing qualifies, the read returns the reserved spurious ID 1023. The processor writes the claimed value back to the completion register to finish handling. A write that matches the most recently claimed interrupt pops the stack and restores the previous running priority. Any other completion write is ignored.

Top module: `cpuif_ack_eoi`

## Requirements
- R1: After reset the request line is low, the control register reads 0 and the threshold register reads 0.
- R2: While control bit 0 is 0, the request line stays low and an acknowledge read returns 1023.
- R3: A candidate is signalled only if its priority value is numerically lower than the 8-bit threshold (register address 1, bits 7:0).
- R4: A candidate is signalled only if its priority value is numerically lower than the running priority. The running priority is the top stack entry, or 0xFF when the stack is empty.
- R5: A claiming acknowledge read (address 2) returns the ID in bits 9:0. Bits 12:10 hold the source CPU when the ID is below 16 and are 0 otherwise. Bits 31:13 are 0.
- R6: An acknowledge read when nothing qualifies returns 1023, changes no state and sends no claim pulse.
- R7: In the cycle after a claiming acknowledge read, the claim output is high for one cycle and carries the claimed ID.
- R8: A completion write (address 3) whose 32-bit data equals the claim word on top of the stack pops that entry, so the running priority returns to its previous value.
- R9: A completion write that does not match the top entry exactly, including a write that gives a wrong source field, leaves the running priority unchanged.
- R10: When the stack holds DEPTH entries, no candidate is signalled and an acknowledge read returns 1023.
- R11: A candidate whose ID is 1020 or above is never signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 2 | 0 control, 1 threshold, 2 acknowledge, 3 completion |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, valid in the cycle regRdEn is high |
| candValid | input | 1 | Distributor offers a candidate |
| candId | input | 10 | Candidate interrupt ID |
| candPrio | input | 8 | Candidate priority (lower is more urgent) |
| candSrc | input | 3 | Requesting CPU for software-generated IDs |
| ackValid | output | 1 | Claim pulse to the distributor |
| ackId | output | 10 | ID claimed |
| irqOut | output | 1 | Interrupt request to the processor |

## Verification
Several properties are checked on every cycle: the request line stays low while disabled, never passes a priority at or above the threshold, never passes a reserved ID and never passes while the stack is full. Every non-claiming acknowledge read returns 1023 and sends no pulse, and every claiming read is followed by a claim pulse that carries the ID. The bench scenarios are what show the stack ordering: nested claims raise the running priority step by step, a matching completion restores it, and mismatched completions, including wrong source fields, leave it as it was. The bench also sweeps every priority against several thresholds and running priorities.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;
  parameter int DATA_W   = 32;
  parameter int ID_W     = 10;
  parameter int PRIO_W   = 8;
  parameter int SRC_W    = 3;
  parameter int ID_LIMIT = 1020;
  parameter int SGI_LIMIT = 16;
  parameter int SPURIOUS = 1023;
  localparam int TAG_W   = ID_W + SRC_W;

  typedef logic [TAG_W-1:0] tag_t;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_PMASK = 2'd1,
    REG_ACK   = 2'd2,
    REG_EOI   = 2'd3
  } regsel_e;

  typedef struct packed {
    logic wrCtrl;
    logic wrMask;
    logic push;
    logic pop;
  } strobe_t;
endpackage

// File: rtl/cpuif_ctrl.sv
module cpuif_ctrl
  import cpuif_pkg::*;
(
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              candValid,
  input  logic [ID_W-1:0]   candId,
  input  logic [PRIO_W-1:0] candPrio,
  input  logic              enQ,
  input  logic [PRIO_W-1:0] maskQ,
  input  logic [PRIO_W-1:0] runPrio,
  input  logic              stackFull,
  input  logic              stackEmpty,
  input  tag_t              topTag,
  output strobe_t           stb,
  output logic              grant
);
  logic idOk;
  logic ackSel;
  logic eoiSel;
  logic tagMatch;

  assign idOk     = candId < ID_W'(ID_LIMIT);
  assign grant    = candValid && idOk && enQ && (candPrio < maskQ) &&
                    (candPrio < runPrio) && !stackFull;
  assign ackSel   = regRdEn && (regAddr == REG_ACK);
  assign eoiSel   = regWrEn && (regAddr == REG_EOI);
  assign tagMatch = regWrData == DATA_W'(topTag);

  always_comb begin
    stb        = '0;
    stb.wrCtrl = regWrEn && (regAddr == REG_CTRL);
    stb.wrMask = regWrEn && (regAddr == REG_PMASK);
    stb.push   = ackSel && grant;
    stb.pop    = eoiSel && !stackEmpty && tagMatch && !(ackSel && grant);
  end
endmodule

// File: rtl/cpuif_dpath.sv
module cpuif_dpath
  import cpuif_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              regRdEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [ID_W-1:0]   candId,
  input  logic [PRIO_W-1:0] candPrio,
  input  logic [SRC_W-1:0]  candSrc,
  output logic              enQ,
  output logic [PRIO_W-1:0] maskQ,
  output logic [PRIO_W-1:0] runPrio,
  output logic              stackFull,
  output logic              stackEmpty,
  output tag_t              topTag,
  output logic [DATA_W-1:0] regRdData,
  output logic              ackValid,
  output logic [ID_W-1:0]   ackId
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PRIO_W-1:0] prioStk [DEPTH];
  tag_t              tagStk  [DEPTH];
  logic [CNT_W-1:0]  depthQ;
  logic [IDX_W-1:0]  topIdx;
  tag_t              ackTag;
  logic [SRC_W-1:0]  srcField;

  assign srcField   = (candId < ID_W'(SGI_LIMIT)) ? candSrc : '0;
  assign ackTag     = {srcField, candId};
  assign stackEmpty = depthQ == '0;
  assign stackFull  = depthQ == CNT_W'(DEPTH);
  assign topIdx     = IDX_W'(depthQ - 1'b1);
  assign runPrio    = stackEmpty ? '1 : prioStk[topIdx];
  assign topTag     = stackEmpty ? '0 : tagStk[topIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ   <= 1'b0;
      maskQ <= '0;
    end else begin
      if (stb.wrCtrl) enQ   <= regWrData[0];
      if (stb.wrMask) maskQ <= regWrData[PRIO_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      depthQ <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        prioStk[i] <= '1;
        tagStk[i]  <= '0;
      end
    end else if (stb.push) begin
      depthQ <= depthQ + 1'b1;
      for (int i = 0; i < DEPTH; i++) begin
        if (depthQ == CNT_W'(i)) begin
          prioStk[i] <= candPrio;
          tagStk[i]  <= ackTag;
        end
      end
    end else if (stb.pop) begin
      depthQ <= depthQ - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackValid <= 1'b0;
      ackId    <= '0;
    end else begin
      ackValid <= stb.push;
      if (stb.push) ackId <= candId;
    end
  end

  always_comb begin
    regRdData = '0;
    if (regRdEn) begin
      case (regAddr)
        REG_CTRL:  regRdData = DATA_W'(enQ);
        REG_PMASK: regRdData = DATA_W'(maskQ);
        REG_ACK:   regRdData = stb.push ? DATA_W'(ackTag) : DATA_W'(SPURIOUS);
        default:   regRdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/cpuif_ack_eoi.sv
module cpuif_ack_eoi
  import cpuif_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              candValid,
  input  logic [ID_W-1:0]   candId,
  input  logic [PRIO_W-1:0] candPrio,
  input  logic [SRC_W-1:0]  candSrc,
  output logic              ackValid,
  output logic [ID_W-1:0]   ackId,
  output logic              irqOut
);
  strobe_t           stb;
  logic              grant;
  logic              enQ;
  logic [PRIO_W-1:0] maskQ;
  logic [PRIO_W-1:0] runPrio;
  logic              stackFull;
  logic              stackEmpty;
  tag_t              topTag;

  cpuif_ctrl u_ctrl (
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .candValid(candValid), .candId(candId),
    .candPrio(candPrio), .enQ(enQ), .maskQ(maskQ), .runPrio(runPrio),
    .stackFull(stackFull), .stackEmpty(stackEmpty), .topTag(topTag),
    .stb(stb), .grant(grant)
  );

  cpuif_dpath #(.DEPTH(DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .candId(candId),
    .candPrio(candPrio), .candSrc(candSrc), .enQ(enQ), .maskQ(maskQ),
    .runPrio(runPrio), .stackFull(stackFull), .stackEmpty(stackEmpty),
    .topTag(topTag), .regRdData(regRdData), .ackValid(ackValid),
    .ackId(ackId)
  );

  assign irqOut = grant;
endmodule

// File: rtl/cpuif_ack_eoi_chk.sv
module cpuif_ack_eoi_chk
  import cpuif_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regRdEn,
  input logic [1:0]        regAddr,
  input logic [DATA_W-1:0] regRdData,
  input logic [ID_W-1:0]   candId,
  input logic [PRIO_W-1:0] candPrio,
  input logic              ackValid,
  input logic [ID_W-1:0]   ackId,
  input logic              irqOut,
  input logic              enQ,
  input logic [PRIO_W-1:0] maskQ,
  input logic              stackFull
);
  logic ackRd;
  assign ackRd = regRdEn && (regAddr == 2'd2);

  // R2
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enQ |-> !irqOut);

  // R3
  below_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (candPrio < maskQ));

  // R6
  spurious_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackRd && !irqOut) |-> (regRdData == DATA_W'(SPURIOUS)));

  // R6
  spurious_no_claim_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ackRd && irqOut) |=> !ackValid);

  // R7
  claim_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackRd && irqOut) |=> (ackValid && ackId == $past(candId)));

  // R10
  full_stack_chk: assert property (@(posedge clk) disable iff (!rstN)
    stackFull |-> !irqOut);

  // R11
  reserved_id_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (candId < ID_W'(ID_LIMIT)));
endmodule

bind cpuif_ack_eoi cpuif_ack_eoi_chk u_chk (
  .clk(clk), .rstN(rstN), .regRdEn(regRdEn), .regAddr(regAddr),
  .regRdData(regRdData), .candId(candId), .candPrio(candPrio),
  .ackValid(ackValid), .ackId(ackId), .irqOut(irqOut), .enQ(enQ),
  .maskQ(maskQ), .stackFull(stackFull)
);

// File: tb/cpuif_ack_eoi_tb.sv
module cpuif_ack_eoi_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        candValid = 1'b0;
  logic [9:0]  candId = '0;
  logic [7:0]  candPrio = '0;
  logic [2:0]  candSrc = '0;
  logic        ackValid;
  logic [9:0]  ackId;
  logic        irqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  cpuif_ack_eoi #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .candValid(candValid), .candId(candId), .candPrio(candPrio),
    .candSrc(candSrc), .ackValid(ackValid), .ackId(ackId), .irqOut(irqOut)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic regPeek(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic doAck(output logic [31:0] d, output logic v, output logic [9:0] i);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = 2'd2;
    #1 d = regRdData;
    @(posedge clk);
    #1 v = ackValid; i = ackId;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic offer(input logic [9:0] id, input logic [7:0] pr, input logic [2:0] src);
    @(negedge clk);
    candValid = 1'b1; candId = id; candPrio = pr; candSrc = src;
    #1;
  endtask

  task automatic irqIs(input bit exp, input string req);
    check(irqOut == exp, req, int'(irqOut), int'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic        v;
    logic [9:0]  i;
    int          prios[4];
    prios = '{8'h80, 8'h60, 8'h40, 8'h20};

    repeat (3) @(posedge clk);
    #1 irqIs(1'b0, "R1");
    rstN = 1'b1;
    regPeek(2'd0, d); check(d == 0, "R1", int'(d), 0);
    regPeek(2'd1, d); check(d == 0, "R1", int'(d), 0);

    // R2: disabled interface stays quiet
    regWrite(2'd1, 32'hF0);
    offer(10'd50, 8'h10, 3'd0);
    irqIs(1'b0, "R2");
    doAck(d, v, i);
    check(d == 1023, "R2", int'(d), 1023);
    check(v == 1'b0, "R6", int'(v), 0);

    regWrite(2'd0, 32'h1);
    regPeek(2'd0, d); check(d == 1, "R2", int'(d), 1);

    // R3: threshold sweep over every priority
    foreach (prios[k]) begin end
    for (int m = 0; m < 6; m++) begin
      int mk;
      mk = (m == 0) ? 0 : (m == 1) ? 1 : (m == 2) ? 8'h80 :
           (m == 3) ? 8'hF0 : (m == 4) ? 8'h37 : 8'hFF;
      regWrite(2'd1, 32'(mk));
      for (int p = 0; p < 256; p++) begin
        offer(10'd40, 8'(p), 3'd0);
        irqIs(p < mk, "R3");
      end
    end
    regWrite(2'd1, 32'hF0);

    // R11: reserved IDs
    for (int id = 1015; id < 1024; id++) begin
      offer(10'(id), 8'h10, 3'd0);
      irqIs(id < 1020, "R11");
    end

    // R5 + R7: claim a software-generated interrupt
    offer(10'd5, 8'h80, 3'd3);
    doAck(d, v, i);
    check(d == ((3 << 10) | 5), "R5", int'(d), (3 << 10) | 5);
    check(v == 1'b1, "R7", int'(v), 1);
    check(i == 10'd5, "R7", int'(i), 5);
    @(negedge clk); #1
    check(ackValid == 1'b0, "R7", int'(ackValid), 0);

    // R4: running priority 0x80 now filters
    for (int p = 0; p < 256; p++) begin
      offer(10'd40, 8'(p), 3'd0);
      irqIs(p < 8'h80, "R4");
    end

    // R5: shared ID carries no source field
    offer(10'd40, 8'h40, 3'd6);
    doAck(d, v, i);
    check(d == 40, "R5", int'(d), 40);

    // R9: mismatched completions ignored
    regWrite(2'd3, (3 << 10) | 5);
    offer(10'd60, 8'h3F, 3'd0); irqIs(1'b1, "R4");
    offer(10'd60, 8'h60, 3'd0); irqIs(1'b0, "R9");
    regWrite(2'd3, (1 << 10) | 40);
    offer(10'd60, 8'h60, 3'd0); irqIs(1'b0, "R9");
    regWrite(2'd3, 32'h8000_0028);
    offer(10'd60, 8'h60, 3'd0); irqIs(1'b0, "R9");

    // R8: matching completion restores 0x80
    regWrite(2'd3, 40);
    offer(10'd60, 8'h60, 3'd0); irqIs(1'b1, "R8");
    offer(10'd60, 8'h7F, 3'd0); irqIs(1'b1, "R8");
    offer(10'd60, 8'h80, 3'd0); irqIs(1'b0, "R8");

    regWrite(2'd3, 5);
    offer(10'd60, 8'h90, 3'd0); irqIs(1'b0, "R9");
    regWrite(2'd3, (3 << 10) | 5);
    offer(10'd60, 8'h90, 3'd0); irqIs(1'b1, "R8");

    // R10: fill the stack
    for (int k = 0; k < DEPTH; k++) begin
      offer(10'(100 + k), 8'(prios[k]), 3'd0);
      doAck(d, v, i);
      check(d == 32'(100 + k), "R10", int'(d), 100 + k);
    end
    offer(10'd200, 8'h00, 3'd0);
    irqIs(1'b0, "R10");
    doAck(d, v, i);
    check(d == 1023, "R10", int'(d), 1023);
    check(v == 1'b0, "R6", int'(v), 0);
    regWrite(2'd3, 103);
    offer(10'd200, 8'h00, 3'd0); irqIs(1'b1, "R10");
    offer(10'd200, 8'h20, 3'd0); irqIs(1'b1, "R8");
    offer(10'd200, 8'h40, 3'd0); irqIs(1'b0, "R8");

    // R6: nothing qualifies, no state change
    offer(10'd200, 8'h50, 3'd0);
    doAck(d, v, i);
    check(d == 1023, "R6", int'(d), 1023);
    check(v == 1'b0, "R6", int'(v), 0);
    offer(10'd200, 8'h3F, 3'd0); irqIs(1'b1, "R6");
    @(negedge clk); candValid = 1'b0; #1 irqIs(1'b0, "R6");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule